// File: doc/BRIEF.md
# E3 Receive Alarm and Parity Monitor

This block watches the overhead of received E3 frames after frame alignment has already been done upstream. A one-cycle strobe marks each frame boundary. On that strobe the block takes the remote-alarm (A) bit and the low nibble of the EM overhead byte. Between strobes it takes payload words through a valid/data pair. It runs two independent checks. The first is a debounce filter on the far-end receive failure (FERF) indication. The second is a 4-bit interleaved parity computed over each frame and compared against the value carried in the next frame.

The results are held in three registers behind a small read port with one cycle of read latency. The interrupt-status register and the error counter reset upon read. A level interrupt output is raised for any flag whose enable is set. An upstream framing-error pulse is also latched into the interrupt-status register.

Top module: `e3_rx_ohmon`

## Requirements
- R1: With `cfg_ferf_long`=0 the FERF status rises on the 3rd consecutive frame strobe with `a_bit`=1. With `cfg_ferf_long`=1 it rises on the 5th. The status becomes visible on `ferf_status` in the cycle after that strobe.
- R2: A set FERF status clears on the 3rd consecutive strobe with `a_bit`=0, or on the 5th when `cfg_ferf_long`=1.
- R3: A strobe whose A bit equals the current FERF status restarts the count of opposite frames. `ferf_status` changes only in the cycle after a strobe.
- R4: Every change of FERF status, whether it is declared or cleared, sets the FERF-change flag, which is bit 3 of address 1.
- R5: Address 0 returns the FERF status in bit 0, and all other bits of address 0 read as 0. Address 3 reads as all zeros.
- R6: Address 1 holds the FERF-change flag in bit 3, the parity-error flag in bit 2 and the framing-error flag in bit 1. A `frm_err` pulse sets the framing-error flag. Bits 15..4 and bit 0 read as 0. A read returns the flags and then clears them. A flag set in the same cycle as the read stays set.
- R7: The parity of a frame is the XOR of every 4-bit nibble of every data word accepted after its strobe and before the next strobe. At the next strobe this value is compared with `em_bip`. A mismatch sets the parity-error flag and increments the error count.
- R8: The first strobe after reset performs no comparison.
- R9: While `cfg_chk_en`=0, no strobe sets the parity-error flag or changes the error count.
- R10: `irq` is high exactly when some flag is set and its enable is set. The enables are `int_en[2]` for bit 3, `int_en[1]` for bit 2 and `int_en[0]` for bit 1.
- R11: Address 2 returns the parity-error count, which saturates at 2^CNT_W-1 and clears when read.
- R12: `rd_data` shows the addressed register in the cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sof | input | 1 | Frame-boundary strobe; overhead inputs are valid with it |
| a_bit | input | 1 | Remote-alarm bit of the frame that begins at the strobe |
| em_bip | input | 4 | Low nibble of the EM byte, carrying the parity of the previous frame |
| data_valid | input | 1 | Payload word valid |
| data_in | input | DW | Payload word |
| frm_err | input | 1 | Framing-error pulse from the aligner |
| cfg_ferf_long | input | 1 | 0: debounce over 3 frames; 1: debounce over 5 frames |
| cfg_chk_en | input | 1 | Enables parity comparison |
| int_en | input | 3 | Interrupt enables for flag bits 3,2,1 |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 2 | Register address |
| rd_data | output | 16 | Read data, one cycle after the request |
| ferf_status | output | 1 | Filtered FERF status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `frame_sof` and `data_valid` are never high in the same cycle. The bench keeps the strobe cycle free of payload and sends payload words only in the cycles between strobes. The assertions also assume that `cfg_ferf_long` is held steady while a debounce count is in progress. The bench changes it only while the run count is zero, and it changes `cfg_chk_en` only between frames, so every property is checked against inputs that obey these rules.

// File: rtl/e3ohm_pkg.sv
package e3ohm_pkg;
    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_INT  = 2'd1,
        ADDR_CNT  = 2'd2,
        ADDR_RSV  = 2'd3
    } reg_addr_e;

    // flag vector order: [2]=ferf change (reg bit 3), [1]=parity (bit 2), [0]=framing (bit 1)
    localparam int FLG_FERF = 2;
    localparam int FLG_PAR  = 1;
    localparam int FLG_FRM  = 0;
    localparam int NFLAGS   = 3;
    localparam int RD_W     = 16;
    localparam int NIB_W    = 4;
endpackage

// File: rtl/e3ohm_ferf_filter.sv
module e3ohm_ferf_filter #(
    parameter int SHORT_N = 3,
    parameter int LONG_N  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic a_bit,
    input  logic long_sel,
    output logic ferf_o,
    output logic change_o
);
    localparam int MAXN = (LONG_N > SHORT_N) ? LONG_N : SHORT_N;
    localparam int RW   = $clog2(MAXN + 1);

    typedef struct packed {
        logic          ferf;
        logic [RW-1:0] run;
    } fstate_t;

    fstate_t s_d, s_q;
    logic [RW-1:0] need;
    logic [RW-1:0] run_inc;

    always_comb begin
        s_d      = s_q;
        change_o = 1'b0;
        need     = long_sel ? RW'(LONG_N) : RW'(SHORT_N);
        run_inc  = s_q.run + 1'b1;
        if (sof) begin
            if (a_bit != s_q.ferf) begin
                if (run_inc >= need) begin
                    s_d.ferf = ~s_q.ferf;
                    s_d.run  = '0;
                    change_o = 1'b1;
                end else begin
                    s_d.run = run_inc;
                end
            end else begin
                s_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ferf_o = s_q.ferf;

    assert_ferf_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(ferf_o));
    assert_run_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run < RW'(MAXN));
endmodule

// File: rtl/e3ohm_bip4.sv
module e3ohm_bip4 #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic [3:0]    em_nib,
    input  logic          dv,
    input  logic [DW-1:0] data,
    input  logic          chk_en,
    output logic          mismatch_o
);
    localparam int NNIB = DW / 4;

    typedef struct packed {
        logic       have;
        logic [3:0] acc;
    } bstate_t;

    bstate_t s_d, s_q;
    logic [3:0] fold;

    always_comb begin
        fold = '0;
        for (int k = 0; k < NNIB; k++) begin
            fold = fold ^ data[k*4 +: 4];
        end
    end

    always_comb begin
        s_d        = s_q;
        mismatch_o = 1'b0;
        if (sof) begin
            mismatch_o = chk_en && s_q.have && (em_nib != s_q.acc);
            s_d.have   = 1'b1;
            s_d.acc    = dv ? fold : 4'h0;
        end else if (dv) begin
            s_d.acc = s_q.acc ^ fold;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_no_check_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> !mismatch_o);
    assert_first_frame_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.have |-> !mismatch_o);
    assert_cmp_only_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> sof);
endmodule

// File: rtl/e3_rx_ohmon.sv
module e3_rx_ohmon
    import e3ohm_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CNT_W   = 16,
    parameter int SHORT_N = 3,
    parameter int LONG_N  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sof,
    input  logic          a_bit,
    input  logic [3:0]    em_bip,
    input  logic          data_valid,
    input  logic [DW-1:0] data_in,
    input  logic          frm_err,
    input  logic          cfg_ferf_long,
    input  logic          cfg_chk_en,
    input  logic [2:0]    int_en,
    input  logic          rd_en,
    input  logic [1:0]    rd_addr,
    output logic [15:0]   rd_data,
    output logic          ferf_status,
    output logic          irq
);
    typedef struct packed {
        logic [NFLAGS-1:0] flags;
        logic [CNT_W-1:0]  cnt;
        logic [RD_W-1:0]   rdat;
    } tstate_t;

    tstate_t s_d, s_q;
    logic ferf_chg, par_bad;
    logic clr_flags, clr_cnt;
    logic [NFLAGS-1:0] set_vec;
    logic [CNT_W-1:0]  cnt_base;

    e3ohm_ferf_filter #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_ferf (
        .clk(clk), .rst_n(rst_n), .sof(frame_sof), .a_bit(a_bit),
        .long_sel(cfg_ferf_long), .ferf_o(ferf_status), .change_o(ferf_chg)
    );

    e3ohm_bip4 #(.DW(DW)) u_bip (
        .clk(clk), .rst_n(rst_n), .sof(frame_sof), .em_nib(em_bip),
        .dv(data_valid), .data(data_in), .chk_en(cfg_chk_en), .mismatch_o(par_bad)
    );

    always_comb begin
        s_d       = s_q;
        clr_flags = rd_en && (rd_addr == ADDR_INT);
        clr_cnt   = rd_en && (rd_addr == ADDR_CNT);
        set_vec   = '0;
        set_vec[FLG_FERF] = ferf_chg;
        set_vec[FLG_PAR]  = par_bad;
        set_vec[FLG_FRM]  = frm_err;
        s_d.flags = (clr_flags ? '0 : s_q.flags) | set_vec;
        cnt_base  = clr_cnt ? '0 : s_q.cnt;
        s_d.cnt   = (par_bad && (cnt_base != {CNT_W{1'b1}})) ? cnt_base + 1'b1 : cnt_base;
        if (rd_en) begin
            unique case (reg_addr_e'(rd_addr))
                ADDR_STAT: s_d.rdat = {{(RD_W-1){1'b0}}, ferf_status};
                ADDR_INT:  s_d.rdat = {{(RD_W-NFLAGS-1){1'b0}}, s_q.flags, 1'b0};
                ADDR_CNT:  s_d.rdat = RD_W'(s_q.cnt);
                ADDR_RSV:  s_d.rdat = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.rdat;
    assign irq     = |(s_q.flags & int_en);

    assert_ferf_change_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ferf_status != $past(ferf_status)) |-> s_q.flags[FLG_FERF]);
    assert_cnt_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == {CNT_W{1'b1}} && !clr_cnt) |=> s_q.cnt == {CNT_W{1'b1}});
    assert_int_reg_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_INT) |=> (rd_data[15:4] == 12'h0 && !rd_data[0]));
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flags == '0) |-> !irq);
endmodule

// File: tb/e3_rx_ohmon_test.sv
module e3_rx_ohmon_test;
    localparam int CW = 4;

    logic clk = 0, rst_n = 0;
    logic frame_sof = 0, a_bit = 0, data_valid = 0, frm_err = 0;
    logic [3:0] em_bip = 0;
    logic [7:0] data_in = 0;
    logic cfg_ferf_long = 0, cfg_chk_en = 1;
    logic [2:0] int_en = 3'b111;
    logic rd_en = 0;
    logic [1:0] rd_addr = 0;
    logic [15:0] rd_data;
    logic ferf_status, irq;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    logic done = 0;

    // bench model
    logic       m_ferf, m_prev;
    int         m_run;
    logic [3:0] m_acc;
    logic [3:0] m_flags;
    int         m_cnt;

    e3_rx_ohmon #(.DW(8), .CNT_W(CW), .SHORT_N(3), .LONG_N(5)) uut (
        .clk(clk), .rst_n(rst_n), .frame_sof(frame_sof), .a_bit(a_bit), .em_bip(em_bip),
        .data_valid(data_valid), .data_in(data_in), .frm_err(frm_err),
        .cfg_ferf_long(cfg_ferf_long), .cfg_chk_en(cfg_chk_en), .int_en(int_en),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ferf_status(ferf_status), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
        end
    end

    task automatic chk(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_flags[3:1] & int_en);
    endfunction

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_ferf = 0; m_prev = 0; m_run = 0; m_acc = 0; m_flags = 0; m_cnt = 0;
    endtask

    // model update for one strobe; returns em value used
    task automatic model_strobe(input logic a, input logic bad, output logic [3:0] em);
        int need;
        need = cfg_ferf_long ? 5 : 3;
        em = bad ? (m_acc ^ 4'h5) : m_acc;
        if (a != m_ferf) begin
            m_run++;
            if (m_run >= need) begin
                m_ferf = ~m_ferf; m_run = 0; m_flags[3] = 1'b1;
            end
        end else m_run = 0;
        if (m_prev && cfg_chk_en && (em != m_acc)) begin
            m_flags[2] = 1'b1;
            if (m_cnt < (1 << CW) - 1) m_cnt++;
        end
        m_prev = 1; m_acc = 0;
    endtask

    task automatic send_frame(input logic a, input logic bad, input int nbytes, input int seed);
        logic [3:0] em;
        model_strobe(a, bad, em);
        @(negedge clk);
        frame_sof = 1; a_bit = a; em_bip = em;
        @(negedge clk);
        frame_sof = 0;
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] b;
            b = 8'(seed * 29 + i * 53 + 7);
            data_valid = 1; data_in = b;
            m_acc = m_acc ^ b[7:4] ^ b[3:0];
            @(negedge clk);
        end
        data_valid = 0;
        chk(ferf_status, m_ferf, "R1/R2/R3 ferf_status");
        chk(irq, exp_irq(), "R10 irq after frame");
    endtask

    task automatic rd(input logic [1:0] addr, output logic [15:0] val);
        @(negedge clk);
        rd_en = 1; rd_addr = addr;
        @(negedge clk);
        rd_en = 0;
        val = rd_data;
    endtask

    task automatic read_int(input string tag);
        logic [15:0] v;
        rd(2'd1, v);
        chk(v, {12'h0, m_flags}, tag);
        m_flags = 0;
    endtask

    task automatic read_cnt(input string tag);
        logic [15:0] v;
        rd(2'd2, v);
        chk(v, m_cnt, tag);
        m_cnt = 0;
    endtask

    initial begin
        logic [15:0] v;
        logic [3:0] em;
        do_reset();
        @(negedge clk);
        chk(ferf_status, 0, "R1 reset ferf");
        chk(irq, 0, "R10 reset irq");
        rd(2'd0, v); chk(v, 0, "R5 reset status");
        read_int("R6 reset int");
        read_cnt("R11 reset count");

        // debounce sweep over both lengths
        for (int L = 0; L < 2; L++) begin
            int n;
            cfg_ferf_long = L[0];
            n = L ? 5 : 3;
            for (int i = 0; i < n - 1; i++) send_frame(1, (i % 3) == 0, i % 5, i + L);
            send_frame(0, 0, 2, 40);                   // R3 restart
            for (int i = 0; i < n; i++) send_frame(1, (i % 2) == 1, (i + 1) % 6, 50 + i);
            chk(ferf_status, 1, "R1 declared after N");
            rd(2'd0, v); chk(v, 1, "R5 status reads ferf");
            read_int("R4 declare flag");
            read_cnt("R7 count after declare phase");
            for (int i = 0; i < n - 1; i++) send_frame(0, 0, 3, 60 + i);
            send_frame(1, 1, 1, 70);                   // R3 restart toward clear
            chk(ferf_status, 1, "R3 still set after restart");
            for (int i = 0; i < n; i++) send_frame(0, (i % 3) == 2, i, 80 + i);
            chk(ferf_status, 0, "R2 cleared after N");
            read_int("R4 clear flag");
            read_cnt("R7 count after clear phase");
        end
        cfg_ferf_long = 0;

        // parity sweep over frame lengths
        for (int nb = 0; nb < 8; nb++) begin
            send_frame(0, nb[0], nb, nb * 3);
            send_frame(0, 0, 7 - nb, nb + 11);
        end
        read_int("R7 parity flags");
        read_cnt("R7 parity count");

        // R9: disabled checking
        @(negedge clk); cfg_chk_en = 0;
        for (int i = 0; i < 4; i++) send_frame(0, 1, 2, i);
        read_int("R9 no flag when disabled");
        read_cnt("R9 no count when disabled");
        @(negedge clk); cfg_chk_en = 1;

        // R8: first frame after reset
        data_valid = 1; data_in = 8'h3C; @(negedge clk); data_valid = 0;
        do_reset();
        send_frame(0, 1, 3, 9);
        read_int("R8 first frame skipped");
        send_frame(0, 0, 2, 9);
        send_frame(0, 1, 2, 9);
        read_int("R8 second comparison active");
        read_cnt("R8 count");

        // R11 saturation
        for (int i = 0; i < 20; i++) send_frame(0, 1, 1, i);
        read_cnt("R11 saturates");
        read_cnt("R11 cleared by read");

        // R6 framing flag, clear on read, set wins over clear
        @(negedge clk); frm_err = 1; @(negedge clk); frm_err = 0;
        m_flags[1] = 1'b1;
        chk(irq, 1, "R6 framing sets irq");
        read_int("R6 framing flag");
        read_int("R6 cleared by read");
        model_strobe(0, 1, em);
        @(negedge clk);
        frame_sof = 1; a_bit = 0; em_bip = em; rd_en = 1; rd_addr = 2'd1;
        @(negedge clk);
        frame_sof = 0; rd_en = 0;
        chk(rd_data, 0, "R6 read returns pre-event flags");
        read_int("R6 same-cycle event kept");
        read_cnt("R6 count");

        // R10 mask sweep
        for (int f = 1; f < 8; f++) begin
            for (int e = 0; e < 8; e++) begin
                @(negedge clk);
                int_en = e[2:0];
                #1;
                chk(irq, 0, "R10 no flags no irq");
            end
            // set flags: bit1 via frm_err, bit2 via bad parity, bit3 via ferf toggle
            if (f[0]) begin @(negedge clk); frm_err = 1; @(negedge clk); frm_err = 0; m_flags[1] = 1; end
            if (f[1]) send_frame(m_ferf, 1, 0, f);
            if (f[2]) for (int i = 0; i < 3; i++) send_frame(~m_ferf, 0, 0, f);
            for (int e = 0; e < 8; e++) begin
                @(negedge clk);
                int_en = e[2:0];
                #1;
                chk(irq, exp_irq(), "R10 masked irq");
            end
            read_int("R10 flags");
            read_cnt("R10 count");
        end
        int_en = 3'b111;

        // R5 / R12 reserved address and latency
        rd(2'd3, v); chk(v, 0, "R5 reserved address");
        rd(2'd0, v); chk(v, m_ferf, "R12 status read latency");

        done = 1;
        summary();
    end
endmodule